// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address for a synchronous burst memory port. A start address is captured whenever either of two address-status strobes is high at a clock edge: one strobe comes from the processor side and one from the cache-controller side. The chip enable is captured in the same edge. After the load, the advance input moves the two lowest address bits through a four-beat burst. The upper address bits stay as they were loaded.

A static order input selects how the low bits step. In linear order they count up modulo four from the start value. In interleaved order the start value is XORed with a beat number that runs 0, 1, 2, 3. While advance is low the address holds, so a burst can stall for any number of cycles. The reset input is asserted asynchronously and released through a two-stage synchronizer inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and until the first load after the synchronized release, addr_out is all zeros and sel_out is 0.
- R2: When strb_cpu or strb_ctl is high at a rising edge, addr_out equals the sampled addr_in from the next cycle on.
- R3: At every load edge, sel_out takes the value of ce sampled at that edge. sel_out keeps that value until the next load.
- R4: Without a load, bits ADDR_W-1:2 of addr_out never change.
- R5: With order_lin=1, each edge with adv high and no strobe sets addr_out[1:0] to (previous value + 1) mod 4.
- R6: With order_lin=0, after k advances (k = 0..3) since a load at start value s, addr_out[1:0] equals s XOR k.
- R7: An edge with adv low and no strobe leaves addr_out unchanged. This is a wait cycle.
- R8: When a strobe and adv are high in the same edge, the load wins: addr_out equals addr_in and is not advanced.
- R9: The fourth advance after a load returns addr_out[1:0] to the start value, in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr_in | input | ADDR_W | External start address |
| strb_cpu | input | 1 | Processor-side address strobe, active high |
| strb_ctl | input | 1 | Controller-side address strobe, active high |
| adv | input | 1 | Burst advance, active high |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved order |
| ce | input | 1 | Chip enable, captured at each load |
| addr_out | output | ADDR_W | Internal memory address |
| sel_out | output | 1 | Chip enable as captured at the last load |

## Verification
The hardest case to reach from the ports is a wait inserted in the middle of a burst, followed by more advances and then the wrap back to the start value. This has to be tried for every start offset in both orders. The stimulus does this by loading each of the four start values through alternating strobes. It then issues four advances with a stall placed after a different beat each time. A strobe is also raised in the same edge as adv, in the middle of a running burst, to show that the load takes priority over the advance.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_rst_sync.sv
module bag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bag_load_reg.sv
module bag_load_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_in,
  output logic [ADDR_W-1:0] base_q,
  output logic              sel_q
);
  logic [ADDR_W-1:0] base_d;
  logic              sel_d;

  always_comb begin
    base_d = base_q;
    sel_d  = sel_q;
    if (load) begin
      base_d = addr_in;
      sel_d  = ce_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      sel_q  <= sel_d;
    end
  end

  // R3: the chip enable is captured only at a load edge
  a_r3_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sel_q == $past(ce_in));
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  assign beat_en = load | adv;

  always_comb begin
    beat_d = beat_q;
    if (load)      beat_d = '0;
    else if (adv)  beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  // R9: the last beat wraps back to zero
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && beat_q == BEAT_LAST) |=> beat_q == '0);
  // R8: a load clears the beat count even when adv is high
  a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat_q == '0);
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_low[i] = start[i] ^ beat[i];
  end

  assign low = (order == ORD_LINEAR) ? lin_low : ilv_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              order_lin,
  input  logic              ce,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              srst_n;
  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low;
  burst_order_e      order;

  assign load  = strb_cpu | strb_ctl;
  assign order = burst_order_e'(order_lin);

  bag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bag_load_reg #(.ADDR_W(ADDR_W)) u_load (
    .clk(clk), .rst_n(srst_n), .load(load), .addr_in(addr_in),
    .ce_in(ce), .base_q(base_q), .sel_q(sel_out)
  );

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(srst_n), .load(load), .adv(adv), .beat_q(beat_q)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order(order), .start(base_q[BEAT_W-1:0]), .beat(beat_q), .low(low)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};

  // R2: either strobe loads the whole address
  a_r2_load: assert property (@(posedge clk) disable iff (!srst_n)
    load |=> addr_out == $past(addr_in));
  // R4: the upper bits only change at a load
  a_r4_upper: assert property (@(posedge clk) disable iff (!srst_n)
    !load |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));
  // R7: a wait cycle holds the address
  a_r7_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!load && !adv) |=> $stable(addr_out));
  // R5: linear order steps the low bits by one
  a_r5_linear: assert property (@(posedge clk) disable iff (!srst_n)
    (!load && adv && order_lin && $stable(order_lin)) |=>
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));
  // R1: nothing is selected while the synchronized reset is low
  a_r1_reset: assert property (@(posedge clk)
    !srst_n |-> (addr_out == '0 && !sel_out));

  initial a_r1_params: assert (UP_W >= 0 && BEAT_W >= 1);
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_cpu, strb_ctl, adv, order_lin, ce;
  logic [AW-1:0] addr_out;
  logic          sel_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-1:0] m_base;
  int            m_beat;
  logic          m_sel;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strb_cpu(strb_cpu),
    .strb_ctl(strb_ctl), .adv(adv), .order_lin(order_lin), .ce(ce),
    .addr_out(addr_out), .sel_out(sel_out)
  );

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] s, k, lo;
    s  = m_base[1:0];
    k  = 2'(m_beat % 4);
    lo = order_lin ? 2'(s + k) : (s ^ k);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc(input logic sc, input logic st, input logic av,
                     input logic c, input logic [AW-1:0] a);
    strb_cpu = sc; strb_ctl = st; adv = av; ce = c; addr_in = a;
    @(posedge clk);
    if (sc || st) begin m_base = a; m_beat = 0; m_sel = c; end
    else if (av)  m_beat++;
    @(negedge clk);
    strb_cpu = 0; strb_ctl = 0; adv = 0;
  endtask

  initial begin
    rst_n = 0; strb_cpu = 0; strb_ctl = 0; adv = 0; order_lin = 0; ce = 0;
    addr_in = '0;
    m_base = '0; m_beat = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", addr_out, '0);
    chk("R1 sel in reset", {17'd0, sel_out}, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 addr after release", addr_out, '0);
    chk("R1 sel after release", {17'd0, sel_out}, '0);

    for (int md = 0; md < 2; md++) begin
      order_lin = md[0];
      for (int s = 0; s < 4; s++) begin
        for (int stall_at = 0; stall_at < 4; stall_at++) begin
          logic [AW-1:0] a;
          logic [AW-1:0] st_addr;
          a = {16'(16'hA5C3 ^ (s * 16'h1111) ^ (stall_at * 16'h0F0F)), 2'(s)};
          cyc(stall_at[0], !stall_at[0], 0, s[0], a);
          chk("R2 load", addr_out, a);
          chk("R3 sel capture", {17'd0, sel_out}, {17'd0, m_sel});
          st_addr = addr_out;
          for (int b = 0; b < 4; b++) begin
            cyc(0, 0, 1, 0, '1);
            chk(md ? "R5 linear step" : "R6 interleaved step", addr_out, expect_addr());
            chk("R4 upper hold", {addr_out[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
            if (b == stall_at) begin
              logic [AW-1:0] held;
              held = addr_out;
              cyc(0, 0, 0, 1, '1);
              cyc(0, 0, 0, 1, '0);
              chk("R7 wait hold", addr_out, held);
              chk("R3 sel kept", {17'd0, sel_out}, {17'd0, m_sel});
            end
          end
          chk("R9 wrap to start", addr_out, st_addr);
        end
      end
      // load together with advance in the middle of a burst
      cyc(1, 0, 0, 1, 18'h12345);
      cyc(0, 0, 1, 0, '0);
      cyc(0, 1, 1, 0, 18'h2ABCE);
      chk("R8 load beats advance", addr_out, 18'h2ABCE);
      chk("R8 sel", {17'd0, sel_out}, 18'd0);
      cyc(0, 0, 1, 0, '0);
      chk(md ? "R5 step after R8" : "R6 step after R8", addr_out, expect_addr());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule